// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block is a first-in first-out buffer placed between two clock domains whose clocks have no fixed phase or frequency relation. A producer in the write domain presents a word with a write request and watches a full flag. A consumer in the read domain issues read requests and watches an empty flag and a used-word count. Storage is a register array written in the write domain and read, through an output register, in the read domain.

Each side owns a position counter that only moves forward and is kept in reflected Gray code, stepped with the help of a separate parity bit. Each counter is carried into the opposite domain through two flip-flops. Full is found in the write domain and empty in the read domain by equality comparison against the carried-over counter. The read-side count is the modular difference between the carried-over write position and the local read position. Requests that would overrun a full buffer or read past an empty one are dropped, so the two positions can never cross.

Top module: `gray_fifo`

## Requirements
- R1: While either reset is held low and just after both are released, `rd_empty` is 1, `wr_full` is 0 and `rd_used` is 0.
- R2: Words leave in the order they were accepted; the word for a read accepted at a `rd_clk` edge appears on `rd_data` after that same edge, and `rd_data` holds its value at edges with no accepted read.
- R3: A write request at a `wr_clk` edge where `wr_full` is 1 is dropped: it stores nothing and moves no position.
- R4: A read request at a `rd_clk` edge where `rd_empty` is 1 is dropped: `rd_data` keeps its value and `rd_used` stays 0.
- R5: `wr_full` rises right after the write edge that makes the buffer hold `2**AW` words, and falls only after reads have freed room and the read position has crossed into the write domain.
- R6: Once both domains have been idle for a few cycles, `rd_used` equals accepted writes minus accepted reads; `rd_used` never exceeds `2**AW`, and `rd_empty` is 1 exactly when `rd_used` is 0.
- R7: Both positions are `AW+1`-bit reflected Gray counters whose value changes in at most one bit per edge and whose parity bit always equals the XOR of the counter bits; counts stay correct across repeated wraps.
- R8: The write position reaches the read domain through two `rd_clk` flip-flops: after a write into an empty buffer, `rd_empty` is still 1 after the first following `rd_clk` edge and is 0 after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_req | input | 1 | Request to store `wr_data` |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Buffer holds `2**AW` words as seen from the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rd_req | input | 1 | Request to take the oldest word |
| rd_data | output | DW | Registered output word |
| rd_empty | output | 1 | No word visible to the read domain |
| rd_used | output | AW+1 | Words held, as seen from the read domain |

## Verification
The assertions assume the two resets are applied together at start-up and released only after each clock has run a few edges, so the synchronizer stages are cleared before any comparison is trusted. They also assume requests and data change only away from their own clock edge. The bench drives every input on the falling edge of its own clock, uses a write clock one quarter the read rate with edges offset from the read edges, and holds both resets through several edges of both clocks before any traffic.

// File: rtl/gray_fifo.sv
`timescale 1ns/1ps
module gray_fifo #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic [AW:0]   rd_used
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] gray_step(input logic [PW-1:0] g, input logic par);
    logic done;
    gray_step = g;
    done = 1'b0;
    if (!par) gray_step[0] = ~g[0];
    else begin
      for (int i = 0; i < PW - 1; i++) begin
        if (!done && g[i]) begin
          gray_step[i+1] = ~g[i+1];
          done = 1'b1;
        end
      end
      if (!done) gray_step[PW-1] = ~g[PW-1];
    end
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    to_bin[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) to_bin[i] = to_bin[i+1] ^ g[i];
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wg, rg, rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] wbin, rbin, rsync_bin, wsync_bin;
  logic          wpar, rpar, wr_go, rd_go;

  assign wbin      = to_bin(wg);
  assign rbin      = to_bin(rg);
  assign rsync_bin = to_bin(rg_s2);
  assign wsync_bin = to_bin(wg_s2);

  assign wr_full  = (wbin[AW] != rsync_bin[AW]) && (wbin[AW-1:0] == rsync_bin[AW-1:0]);
  assign rd_empty = (rg == wg_s2);
  assign rd_used  = wsync_bin - rbin;
  assign wr_go    = wr_req && !wr_full;
  assign rd_go    = rd_req && !rd_empty;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wg    <= '0;
      wpar  <= 1'b0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rg;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wg   <= gray_step(wg, wpar);
        wpar <= ~wpar;
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rg      <= '0;
      rpar    <= 1'b0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      rd_data <= '0;
    end else begin
      wg_s1 <= wg;
      wg_s2 <= wg_s1;
      if (rd_go) begin
        rg      <= gray_step(rg, rpar);
        rpar    <= ~rpar;
        rd_data <= mem[rbin[AW-1:0]];
      end
    end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_req && wr_full) |=> $stable(wg)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_req && rd_empty) |=> ($stable(rg) && $stable(rd_data))); // R4
  AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $onehot0(wg ^ $past(wg))); // R7
  AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $onehot0(rg ^ $past(rg))); // R7
  AST_WR_PARITY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wpar == ^wg); // R7
  AST_RD_PARITY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rpar == ^rg); // R7
  AST_USED_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_used <= DEPTH_P); // R6
  AST_EMPTY_USED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty == (rd_used == '0)); // R6
  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_go |=> $stable(rd_data)); // R2
endmodule

// File: tb/tb_gray_fifo.sv
`timescale 1ns/1ps
module tb_gray_fifo;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_req = 0, rd_req = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic wr_full, rd_empty;
  logic [AW:0] rd_used;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];

  gray_fifo #(.DW(DW), .AW(AW)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_used(rd_used));

  always #2.5 rd_clk = ~rd_clk;
  initial begin
    #1;
    forever #10 wr_clk = ~wr_clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic wr1(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_req = 1; wr_data = d;
    if (!wr_full) q.push_back(d);
    @(negedge wr_clk);
    wr_req = 0;
  endtask

  task automatic rd1(input string tag);
    logic was_empty;
    logic [DW-1:0] prev, exp;
    @(negedge rd_clk);
    was_empty = rd_empty; prev = rd_data;
    rd_req = 1;
    @(negedge rd_clk);
    rd_req = 0;
    if (!was_empty) begin
      exp = q.pop_front();
      chk({tag, " R2 order"}, rd_data, exp);
    end else begin
      chk("R4 data held on empty read", rd_data, prev);
      chk("R4 used stays 0", rd_used, 0);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge wr_clk);
    @(negedge rd_clk);
  endtask

  initial begin
    repeat (4) @(negedge wr_clk);
    chk("R1 empty in reset", rd_empty, 1);
    chk("R1 full in reset", wr_full, 0);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rd_clk);
    chk("R1 empty after reset", rd_empty, 1);
    chk("R1 full after reset", wr_full, 0);
    chk("R1 used after reset", rd_used, 0);

    // R4: reads on an empty buffer
    rd1("r4_");
    rd1("r4_");

    // R8: two-stage crossing of the write position
    @(negedge wr_clk);
    wr_req = 1; wr_data = 8'hA5; q.push_back(8'hA5);
    @(posedge wr_clk);
    @(posedge rd_clk);
    wr_req = 0;
    @(negedge rd_clk);
    chk("R8 empty after one rd edge", rd_empty, 1);
    @(posedge rd_clk);
    @(negedge rd_clk);
    chk("R8 empty after two rd edges", rd_empty, 0);
    rd1("r8_");

    // Sweep every fill level, including overfill
    for (int k = 0; k <= DEPTH + 2; k++) begin
      for (int i = 0; i < k; i++) begin
        wr1(DW'(k * 16 + i));
        if (i == DEPTH - 1) begin
          @(negedge wr_clk);
          chk("R5 full right after last fitting write", wr_full, 1);
        end
      end
      settle();
      chk("R6 settled used", rd_used, (k < DEPTH) ? k : DEPTH);
      chk("R6 empty iff zero", rd_empty, (k == 0) ? 1 : 0);
      chk("R3 full when overfilled", wr_full, (k >= DEPTH) ? 1 : 0);
      if (k >= DEPTH) begin
        rd1("r5_");
        @(negedge wr_clk);
        chk("R5 full held until read crosses", wr_full, 1);
        settle();
        chk("R5 full released", wr_full, 0);
      end
      while (q.size() > 0) rd1("r3_");
      rd1("r4_");
      settle();
      chk("R6 used after drain", rd_used, 0);
    end

    // Random concurrent traffic with scoreboard
    fork
      begin
        repeat (400) begin
          @(negedge wr_clk);
          wr_req = $urandom % 2;
          wr_data = DW'($urandom);
          if (wr_req && !wr_full) q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_req = 0;
      end
      begin
        logic pend;
        logic [DW-1:0] exp;
        pend = 0; exp = '0;
        for (int c = 0; c < 1700; c++) begin
          @(negedge rd_clk);
          if (pend) chk("R2 random order", rd_data, exp);
          checks++;
          if (int'(rd_used) > q.size()) begin
            errors++;
            $display("FAIL R6 used above held actual=%0d expected<=%0d", rd_used, q.size());
          end
          rd_req = (c < 800) ? (($urandom % 8) == 0) : (($urandom % 8) < 5);
          pend = rd_req && !rd_empty;
          if (pend) exp = q.pop_front();
        end
        @(negedge rd_clk);
        if (pend) chk("R2 random order", rd_data, exp);
        rd_req = 0;
      end
    join
    settle();
    chk("R7 used correct after many wraps", rd_used, q.size());
    while (q.size() > 0) rd1("r7_");
    settle();
    chk("R6 used after final drain", rd_used, 0);
    chk("R6 empty after final drain", rd_empty, 1);
    chk("R5 not full after final drain", wr_full, 0);
    summary();
  end
endmodule